// File: doc/BRIEF.md
# Serial-Stream Time Slot Interchanger

This block turns one frame of bytes collected from a parallel backbone into eight serial TDM output streams. A frame-sized data store holds the backbone bytes. A connection store holds one entry per serial output slot. The entry either names the store address of the byte to send, or carries a byte that software placed there to be sent as is. The block also generates the frame and bit timing for three serial rates, and gives each slot its own drive enable and pin direction.

The data store has two pages, and the pages swap at every serial frame start. Bytes written during one frame leave together during the next frame. A multi-slot wideband channel therefore always leaves from a single input frame. A frame start comes from an 8 kHz frame pulse. The idle level of that pulse is learnt after reset, and it shows which framing convention is in use. Without a pulse, the slot counter wraps on its own after the last bit of the last channel.

Top module: `tsi_serial_out`

## Requirements
- R1: While reset is held, `serOut`, `serOe`, `serDirIn` and `gciFormat` are all 0.
- R2: The first clock edge of a frame start loads channel 0. Bit 7 of that channel is on `serOut` from that edge onward. Bits follow most significant first, and channels follow in ascending order. Rate code 0 gives 32 channels per stream and code 1 gives 64 channels, with every bit held for two clocks. Codes 2 and 3 give 128 channels with one clock per bit. Outputs change only on the first clock of a bit.
- R3: A connection entry sits at index stream*128+channel and has these fields: bits 7:0 the low byte, bit 8 the message flag, bit 9 the drive enable and bit 10 the input direction. When the message flag is 0, the slot sends the data-store byte at address low[5:0].
- R4: When the message flag is 1, the slot sends the low byte of its entry.
- R5: When the drive enable is 0, `serOe` is low for that slot. When it is 1 and the direction is output, `serOe` is high. `serOe` changes only at slot loads.
- R6: When the direction bit is 1, `serDirIn` is high and `serOe` is low for that slot.
- R7: Data-store writes go to the page that is not being read. Bytes written during a frame are sent in the following frame, and a write during a frame does not change that frame's output.
- R8: On the first clock after reset, the frame pulse level is taken as idle. A frame start is the first clock at which the pulse differs from idle, so a pulse held for several clocks counts once. `gciFormat` is 1 when the idle level is 0. `gciFormat` does not fall until the next reset.
- R9: Without a frame pulse, a new frame starts right after the last bit of the last channel.
- R10: The rate code is sampled only at a frame start. A change in the middle of a frame takes effect at the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock: twice the bit rate for codes 0 and 1, equal to the bit rate for codes 2 and 3 |
| rstN | input | 1 | Active-low synchronous reset |
| rateSel | input | 2 | Serial rate code, sampled at each frame start |
| framePulse | input | 1 | 8 kHz frame pulse, either polarity |
| dmWrEn | input | 1 | Data-store write strobe |
| dmWrAddr | input | 6 | Data-store byte address |
| dmWrData | input | 8 | Backbone byte to store |
| cmWrEn | input | 1 | Connection-store write strobe |
| cmWrAddr | input | 10 | Connection index {stream, channel} |
| cmWrData | input | 11 | Connection entry {direction, drive, message, low byte} |
| serOut | output | 8 | Serial data, one bit per stream |
| serOe | output | 8 | Per-stream drive enable for the current slot |
| serDirIn | output | 8 | Per-stream pin-is-input flag for the current slot |
| gciFormat | output | 1 | 1 when frame pulses are active high |

## Verification
The bench uses the default build: eight streams, 128 channel slots per stream and a 64-byte page. This lets every rate code, including the full 128-channel frame, run end to end with all 1024 connection entries in use. With a 64-byte page, all six address bits of each entry's low byte reach the data store. Frames of 512 and 1024 clocks keep the free-running wrap, the mid-frame rate change and both pulse polarities inside a short run.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int STREAMS  = 8;
  localparam int CH_W     = 7;
  localparam int MAX_CH   = 1 << CH_W;
  localparam int DM_DEPTH = 64;

  // connection entry: bit10 input direction, bit9 drive, bit8 message, 7:0 low byte
  typedef struct packed {
    logic       dirIn;
    logic       drive;
    logic       msg;
    logic [7:0] low;
  } cmEntry_t;

  typedef struct packed {
    logic            frameStart;
    logic            load;
    logic            shift;
    logic [CH_W-1:0] loadCh;
    logic            rdPage;
    logic            wrPage;
    logic [1:0]      rate;
  } ctrlStrb_t;
endpackage

// File: rtl/tsi_frame_ctrl.sv
module tsi_frame_ctrl
  import tsi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] rateSel,
  input  logic       framePulse,
  output ctrlStrb_t  strb,
  output logic       gciFormat
);
  localparam logic [CH_W-1:0] LAST_Q = CH_W'(MAX_CH / 4 - 1);
  localparam logic [CH_W-1:0] LAST_H = CH_W'(MAX_CH / 2 - 1);
  localparam logic [CH_W-1:0] LAST_F = CH_W'(MAX_CH - 1);

  logic            phase;
  logic [2:0]      bitCnt;
  logic [CH_W-1:0] chCnt;
  logic            wrPage;
  logic [1:0]      rate;
  logic            fpIdle, fpSeen, fpPrev;

  logic            twoClk, endBit, chEnd, wrapHit, fpDetect, frameStart;
  logic [CH_W-1:0] chLast;

  always_comb begin
    twoClk = (rate < 2'd2);
    unique case (rate)
      2'd0:    chLast = LAST_Q;
      2'd1:    chLast = LAST_H;
      default: chLast = LAST_F;
    endcase
    endBit     = !twoClk || phase;
    chEnd      = endBit && (bitCnt == 3'd7);
    wrapHit    = chEnd && (chCnt == chLast);
    fpDetect   = fpSeen && (framePulse != fpIdle) && (fpPrev == fpIdle);
    frameStart = fpDetect || wrapHit;
  end

  always_comb begin
    strb.frameStart = frameStart;
    strb.load       = frameStart || chEnd;
    strb.shift      = endBit && !chEnd && !frameStart;
    strb.loadCh     = frameStart ? '0 : chCnt + 1'b1;
    strb.rdPage     = frameStart ? wrPage : ~wrPage;
    strb.wrPage     = wrPage;
    strb.rate       = rate;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fpIdle <= 1'b0;
      fpSeen <= 1'b0;
      fpPrev <= 1'b0;
    end else begin
      fpPrev <= framePulse;
      if (!fpSeen) begin
        fpIdle <= framePulse;
        fpSeen <= 1'b1;
      end
    end
  end

  assign gciFormat = fpSeen && !fpIdle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= 1'b0;
      bitCnt <= '0;
      chCnt  <= '0;
      wrPage <= 1'b0;
      rate   <= 2'd0;
    end else if (frameStart) begin
      phase  <= 1'b0;
      bitCnt <= '0;
      chCnt  <= '0;
      wrPage <= ~wrPage;
      rate   <= rateSel;
    end else if (endBit) begin
      phase <= 1'b0;
      if (bitCnt == 3'd7) begin
        bitCnt <= '0;
        chCnt  <= chCnt + 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end else begin
      phase <= 1'b1;
    end
  end
endmodule

// File: rtl/tsi_slot_dpath.sv
module tsi_slot_dpath
  import tsi_pkg::*;
#(
  parameter int NUM_STREAMS = STREAMS,
  parameter int DM_WORDS    = DM_DEPTH
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  ctrlStrb_t                              strb,
  input  logic                                   dmWrEn,
  input  logic [$clog2(DM_WORDS)-1:0]            dmWrAddr,
  input  logic [7:0]                             dmWrData,
  input  logic                                   cmWrEn,
  input  logic [$clog2(NUM_STREAMS)+CH_W-1:0]    cmWrAddr,
  input  logic [10:0]                            cmWrData,
  output logic [NUM_STREAMS-1:0]                 serOut,
  output logic [NUM_STREAMS-1:0]                 serOe,
  output logic [NUM_STREAMS-1:0]                 serDirIn
);
  localparam int ST_W     = $clog2(NUM_STREAMS);
  localparam int DM_AW    = $clog2(DM_WORDS);
  localparam int CM_WORDS = NUM_STREAMS * MAX_CH;

  logic [7:0]  dmem [2][DM_WORDS];
  logic [10:0] cmem [CM_WORDS];

  always_ff @(posedge clk) begin
    if (dmWrEn) dmem[strb.wrPage][dmWrAddr] <= dmWrData;
    if (cmWrEn) cmem[cmWrAddr] <= cmWrData;
  end

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    cmEntry_t   ent;
    logic [7:0] srcByte;
    logic [7:0] shReg;
    logic       oeReg, dirReg;

    always_comb begin
      ent     = cmEntry_t'(cmem[{ST_W'(s), strb.loadCh}]);
      srcByte = ent.msg ? ent.low : dmem[strb.rdPage][ent.low[DM_AW-1:0]];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shReg  <= '0;
        oeReg  <= 1'b0;
        dirReg <= 1'b0;
      end else if (strb.load) begin
        shReg  <= srcByte;
        oeReg  <= ent.drive && !ent.dirIn;
        dirReg <= ent.dirIn;
      end else if (strb.shift) begin
        shReg <= {shReg[6:0], 1'b0};
      end
    end

    assign serOut[s]   = shReg[7];
    assign serOe[s]    = oeReg;
    assign serDirIn[s] = dirReg;
  end
endmodule

// File: rtl/tsi_serial_out.sv
module tsi_serial_out
  import tsi_pkg::*;
#(
  parameter int NUM_STREAMS = STREAMS,
  parameter int DM_WORDS    = DM_DEPTH
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [1:0]                          rateSel,
  input  logic                                framePulse,
  input  logic                                dmWrEn,
  input  logic [$clog2(DM_WORDS)-1:0]         dmWrAddr,
  input  logic [7:0]                          dmWrData,
  input  logic                                cmWrEn,
  input  logic [$clog2(NUM_STREAMS)+CH_W-1:0] cmWrAddr,
  input  logic [10:0]                         cmWrData,
  output logic [NUM_STREAMS-1:0]              serOut,
  output logic [NUM_STREAMS-1:0]              serOe,
  output logic [NUM_STREAMS-1:0]              serDirIn,
  output logic                                gciFormat
);
  ctrlStrb_t strb;

  tsi_frame_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rateSel    (rateSel),
    .framePulse (framePulse),
    .strb       (strb),
    .gciFormat  (gciFormat)
  );

  tsi_slot_dpath #(
    .NUM_STREAMS (NUM_STREAMS),
    .DM_WORDS    (DM_WORDS)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dmWrEn   (dmWrEn),
    .dmWrAddr (dmWrAddr),
    .dmWrData (dmWrData),
    .cmWrEn   (cmWrEn),
    .cmWrAddr (cmWrAddr),
    .cmWrData (cmWrData),
    .serOut   (serOut),
    .serOe    (serOe),
    .serDirIn (serDirIn)
  );
endmodule

// File: rtl/tsi_serial_out_chk.sv
module tsi_serial_out_chk #(
  parameter int NUM_STREAMS = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_STREAMS-1:0] serOut,
  input logic [NUM_STREAMS-1:0] serOe,
  input logic                   gciFormat,
  input logic                   frameStart,
  input logic                   loadStb,
  input logic                   shiftStb,
  input logic                   wrPage,
  input logic [1:0]             rate
);
  assert_out_moves_on_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serOut) |-> $past(loadStb || shiftStb));

  assert_oe_moves_on_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serOe) |-> $past(loadStb));

  assert_page_flips_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (wrPage != $past(wrPage)));

  assert_format_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(gciFormat));

  assert_rate_at_frame_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rate) |-> $past(frameStart));
endmodule

bind tsi_serial_out tsi_serial_out_chk #(.NUM_STREAMS(NUM_STREAMS)) chk (
  .clk        (clk),
  .rstN       (rstN),
  .serOut     (serOut),
  .serOe      (serOe),
  .gciFormat  (gciFormat),
  .frameStart (strb.frameStart),
  .loadStb    (strb.load),
  .shiftStb   (strb.shift),
  .wrPage     (strb.wrPage),
  .rate       (strb.rate)
);

// File: tb/tsi_serial_out_test.sv
module tsi_serial_out_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int NROWS = 6;
  // each row: {rate code[9:8], seed[7:0]}
  localparam logic [9:0] ROWS [NROWS] = '{10'h001, 10'h102, 10'h203, 10'h304, 10'h005, 10'h206};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  rateSel = 2'd0;
  logic        framePulse = 1'b1;
  logic        dmWrEn = 1'b0;
  logic [5:0]  dmWrAddr = '0;
  logic [7:0]  dmWrData = '0;
  logic        cmWrEn = 1'b0;
  logic [9:0]  cmWrAddr = '0;
  logic [10:0] cmWrData = '0;
  logic [7:0]  serOut, serOe, serDirIn;
  logic        gciFormat;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsi_serial_out uut (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .framePulse(framePulse),
    .dmWrEn(dmWrEn), .dmWrAddr(dmWrAddr), .dmWrData(dmWrData),
    .cmWrEn(cmWrEn), .cmWrAddr(cmWrAddr), .cmWrData(cmWrData),
    .serOut(serOut), .serOe(serOe), .serDirIn(serDirIn), .gciFormat(gciFormat)
  );

  function automatic logic [10:0] entryOf(int seed, int s, int c);
    logic [10:0] e;
    e[7:0] = 8'(seed * 7 + s * 13 + c * 5);
    e[8]   = ((s + c + seed) % 3 == 0);
    e[9]   = ((s * 3 + c + seed) % 5 != 0);
    e[10]  = ((c + seed) % 7 == 0);
    return e;
  endfunction

  function automatic logic [7:0] dmOf(int seed, int a);
    return 8'(a * 29 + seed * 11 + 3);
  endfunction

  function automatic logic [7:0] expByte(int seed, int s, int c);
    logic [10:0] e;
    e = entryOf(seed, s, c);
    return e[8] ? e[7:0] : dmOf(seed, int'(e[5:0]));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic cmWrite(input int idx, input logic [10:0] data);
    @(negedge clk);
    cmWrEn = 1'b1; cmWrAddr = 10'(idx); cmWrData = data;
  endtask

  task automatic dmWrite(input int addr, input logic [7:0] data);
    @(negedge clk);
    dmWrEn = 1'b1; dmWrAddr = 6'(addr); dmWrData = data;
  endtask

  task automatic busIdle();
    @(negedge clk);
    cmWrEn = 1'b0; dmWrEn = 1'b0;
  endtask

  // drives the active level; returns right after the frame-start edge
  task automatic pulseEdge(input logic idleLvl);
    @(negedge clk);
    framePulse = ~idleLvl;
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    check(serOut == 0 && serOe == 0 && serDirIn == 0 && gciFormat == 0, "R1", {serOut, serOe}, 0, "outputs in reset");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(gciFormat == 1'b0, "R8", gciFormat, 0, "idle-high pulse format");

    // table walk
    for (int r = 0; r < NROWS; r++) begin
      int rate, seed, cpb, nch, frameClk;
      rate = int'(ROWS[r][9:8]);
      seed = int'(ROWS[r][7:0]);
      cpb  = (rate < 2) ? 2 : 1;
      nch  = (rate == 0) ? 32 : (rate == 1) ? 64 : 128;
      frameClk = nch * 8 * cpb;
      for (int i = 0; i < NS * 128; i++) cmWrite(i, entryOf(seed, i / 128, i % 128));
      busIdle();
      rateSel = 2'(rate);
      pulseEdge(1'b1);
      @(negedge clk); framePulse = 1'b1;
      for (int a = 0; a < 64; a++) dmWrite(a, dmOf(seed, a));
      busIdle();
      pulseEdge(1'b1);
      for (int n = 0; n < frameClk; n++) begin
        int bIdx, c, b;
        @(negedge clk);
        if (n == 0) framePulse = 1'b1;
        // R7: writes during the frame land on the other page
        dmWrEn = 1'b1; dmWrAddr = 6'(n % 64); dmWrData = 8'(~dmOf(seed, n % 64));
        bIdx = n / cpb; c = bIdx / 8; b = 7 - (bIdx % 8);
        for (int s = 0; s < NS; s++) begin
          logic [10:0] e;
          logic ex;
          e = entryOf(seed, s, c);
          ex = expByte(seed, s, c)[b];
          check(serOut[s] == ex, e[8] ? "R4" : "R3 R7 R2", serOut[s], ex, "serial bit");
          if (n % (8 * cpb) == 0) begin
            check(serDirIn[s] == e[10], "R6", serDirIn[s], e[10], "direction");
            check(serOe[s] == (e[9] && !e[10]), "R5 R6", serOe[s], e[9] && !e[10], "drive enable");
          end
        end
      end
      busIdle();
    end

    // R9 R10: free wrap and rate sampled only at frame start
    cmWrite(0, 11'h3A5);
    cmWrite(1, 11'h33C);
    busIdle();
    rateSel = 2'd0;
    pulseEdge(1'b1);
    for (int n = 0; n < 526; n++) begin
      @(negedge clk);
      if (n == 0) begin framePulse = 1'b1; rateSel = 2'd2; end
      case (n)
        0:   check(serOut[0] == 1'b1, "R2", serOut[0], 1, "bit7 after start");
        1:   check(serOut[0] == 1'b1, "R10 R2", serOut[0], 1, "bit held two clocks");
        2:   check(serOut[0] == 1'b0, "R10", serOut[0], 0, "bit6 of first slot");
        16:  check(serOut[0] == 1'b0, "R2", serOut[0], 0, "ch1 bit7");
        20:  check(serOut[0] == 1'b1, "R2", serOut[0], 1, "ch1 bit5");
        512: check(serOut[0] == 1'b1, "R9", serOut[0], 1, "wrap bit7 ch0");
        513: check(serOut[0] == 1'b0, "R10", serOut[0], 0, "new rate bit6");
        520: check(serOut[0] == 1'b0, "R10 R9", serOut[0], 0, "new rate ch1 bit7");
        522: check(serOut[0] == 1'b1, "R10 R9", serOut[0], 1, "new rate ch1 bit5");
        default: ;
      endcase
    end

    // R8: active-high pulses, held three clocks
    @(negedge clk);
    rstN = 1'b0; framePulse = 1'b0; rateSel = 2'd0;
    repeat (3) @(negedge clk);
    check(serOut == 0 && serOe == 0 && serDirIn == 0, "R1", {serOut, serOe}, 0, "outputs in second reset");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(gciFormat == 1'b1, "R8", gciFormat, 1, "idle-low pulse format");
    pulseEdge(1'b0);
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      if (n == 2) framePulse = 1'b0;
      case (n)
        0: check(serOut[0] == 1'b1, "R8", serOut[0], 1, "held pulse bit7");
        2: check(serOut[0] == 1'b0, "R8", serOut[0], 0, "held pulse counts once bit6");
        4: check(serOut[0] == 1'b1, "R8", serOut[0], 1, "held pulse bit5");
        6: check(serOut[0] == 1'b0, "R8", serOut[0], 0, "held pulse bit4");
        default: ;
      endcase
    end
    check(gciFormat == 1'b1, "R8", gciFormat, 1, "format kept");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule